// File: doc/BRIEF.md
# Spectral Line Capture and Burst Writer

This block sits between a slow serial spectrum source and a fast raster refresh memory. At a fixed interval of one second it pulses a scan request. The source then delivers two points per delay cell, each on its own strobe, over tens of milliseconds. The block folds each neighbouring pair of points into one delay cell with a logical OR, so that an isolated hit always survives, and it holds the cells in a temporary register.

Once a line is captured, the block waits until the refresh memory announces the start of the raster line it is going to fill. It then writes the whole line in one run of back-to-back cycles, two dot positions per cycle (one even, one odd). The dot positions at the top of each line are left alone for bargraph data written by other logic. After each burst the target line moves on by one. At the end of the sweep it wraps to line zero and pulses a marker. A request that falls due while a line is still waiting or being written is held back, and it is issued as soon as the write finishes.

Top module: `line_capture_burst`

## Requirements
- R1: `scan_req` is a one-cycle pulse. With the block idle, it is high in the cycle after each `SEC_TICKS`-th clock since reset, so requests fall every `SEC_TICKS` cycles.
- R2: Points are accepted only while a line is loading, between a request and the `2*CELLS`-th accepted strobe. Strobes outside that window change no stored cell.
- R3: Cell k holds the OR of accepted points 2k and 2k+1, with point 0 the first accepted after the request.
- R4: A burst starts in the cycle after a `ln_start` pulse whose `ln_cur` equals `wr_line`. It then holds `wr_en` high for `CELLS/2` consecutive cycles, and no earlier than the capture is complete.
- R5: On burst beat j, `wr_pair` = `RSV_DOTS/2 + j`, `wr_even` = cell 2j and `wr_odd` = cell 2j+1. Pair addresses below `RSV_DOTS/2` (the reserved top dots) are never written. Outside a burst, `wr_pair`, `wr_even` and `wr_odd` are 0.
- R6: `wr_line` stays steady except in the cycle after a burst ends, when it goes up by one.
- R7: After a burst on line `LINES-1`, `wr_line` becomes 0 and `sweep_done` is high for exactly that one cycle.
- R8: A request interval that expires while the block is not idle does not interrupt the block. One request, however many intervals expired, is issued two cycles after the last burst beat.
- R9: While `rst_n` is low, `scan_req`, `wr_en` and `sweep_done` are low and `wr_line` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock (one pair written per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Point strobe from the spectrum source |
| smp_bit | input | 1 | Point value qualified by `smp_stb` |
| ln_start | input | 1 | Raster line-start pulse from the refresh memory |
| ln_cur | input | $clog2(LINES) | Raster line that `ln_start` announces |
| scan_req | output | 1 | One-cycle request for a new spectral scan |
| wr_en | output | 1 | Write strobe to the refresh memory |
| wr_line | output | $clog2(LINES) | Target raster line |
| wr_pair | output | $clog2((RSV_DOTS+CELLS)/2) | Even/odd dot pair address within the line |
| wr_even | output | 1 | Data for the even dot of the pair |
| wr_odd | output | 1 | Data for the odd dot of the pair |
| sweep_done | output | 1 | Pulse when the line index wraps to 0 |

## Verification
A slip in the point counter or the pair fold shows as wrong `wr_even`/`wr_odd` bits on the very burst that follows, as much as a raster pass after the capture. A wrong sequencer state shows at once as `scan_req` or `wr_en` in a cycle where the model has none. A wrong line index shows on `wr_line` in the cycle after the burst. Faults in the delay or merging of overdue requests show in the cycle after the burst returns to idle, because the request comes early, late, twice or not at all. The bench drives stray strobes between scans and leaves long raster waits, so these faults are reached.

// File: rtl/lcap_pkg.sv
// Package lcap_pkg: shared types for the line capture block.
// Assumes: nothing beyond IEEE 1800-2017.
package lcap_pkg;

    // Sequencer phases, in the order a line passes through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_LOAD  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_BURST = 3'd4
    } seq_state_t;

endpackage

// File: rtl/lcap_sec_timer.sv
// Module lcap_sec_timer: free-running interval timer.
// Pulses tick for one cycle every TICKS clocks, first at clock TICKS-1 after reset.
// Assumes: TICKS >= 2.
module lcap_sec_timer #(
    parameter int TICKS = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(TICKS);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == CNT_W'(TICKS - 1));

    // Count clocks and restart when the interval ends.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/lcap_pair_buffer.sv
// Module lcap_pair_buffer: folds serial points pairwise into delay cells and
// replays them two cells per cycle.
// Assumes: clr comes before a capture; cap_en and shift2 are never both high.
module lcap_pair_buffer #(
    parameter int CELLS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cap_en,
    input  logic       smp_stb,
    input  logic       smp_bit,
    input  logic       shift2,
    output logic       load_done,
    output logic [1:0] cell_lo
);
    localparam int PTS  = 2 * CELLS;
    localparam int PT_W = $clog2(PTS + 1);

    logic [PT_W-1:0]  pt_q;
    logic             acc_q;
    logic [CELLS-1:0] sr_q;
    logic             take;

    assign take      = cap_en && smp_stb;
    assign load_done = take && (pt_q == PT_W'(PTS - 1));
    assign cell_lo   = sr_q[1:0];

    // Count accepted points and hold the first point of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pt_q  <= '0;
            acc_q <= 1'b0;
        end else if (take) begin
            pt_q <= pt_q + 1'b1;
            if (!pt_q[0]) acc_q <= smp_bit;
        end
    end

    // Shift in a folded cell at the top; drain two cells from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (take && pt_q[0])
            sr_q <= {acc_q | smp_bit, sr_q[CELLS-1:1]};
        else if (shift2)
            sr_q <= {2'b00, sr_q[CELLS-1:2]};
    end
endmodule

// File: rtl/lcap_sequencer.sv
// Module lcap_sequencer: phase control, request deferral, burst addressing
// and line index.
// Assumes: load_done comes only while cap_en is high.
module lcap_sequencer
    import lcap_pkg::*;
#(
    parameter int CELLS    = 100,
    parameter int RSV_DOTS = 28,
    parameter int LINES    = 280
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 tick,
    input  logic                                 load_done,
    input  logic                                 ln_start,
    input  logic [$clog2(LINES)-1:0]             ln_cur,
    output logic                                 clr,
    output logic                                 cap_en,
    output logic                                 shift2,
    output logic                                 scan_req,
    output logic                                 wr_en,
    output logic [$clog2(LINES)-1:0]             wr_line,
    output logic [$clog2((RSV_DOTS+CELLS)/2)-1:0] wr_pair,
    output logic                                 sweep_done
);
    localparam int BEATS     = CELLS / 2;
    localparam int BEAT_W    = $clog2(BEATS);
    localparam int PAIR_W    = $clog2((RSV_DOTS + CELLS) / 2);
    localparam int PAIR_BASE = RSV_DOTS / 2;
    localparam int LINE_W    = $clog2(LINES);

    seq_state_t        st_q;
    logic              pend_q;
    logic [BEAT_W-1:0] beat_q;
    logic [LINE_W-1:0] line_q;
    logic              sweep_q;
    logic              last_beat;
    logic              line_hit;

    assign last_beat = (st_q == ST_BURST) && (beat_q == BEAT_W'(BEATS - 1));
    assign line_hit  = ln_start && (ln_cur == line_q);

    // Step through the phases of one line.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE:  if (tick || pend_q) st_q <= ST_REQ;
                ST_REQ:   st_q <= ST_LOAD;
                ST_LOAD:  if (load_done) st_q <= ST_WAIT;
                ST_WAIT:  if (line_hit) st_q <= ST_BURST;
                ST_BURST: if (last_beat) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Remember an interval that expired while busy; clear it once idle.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q == ST_IDLE) pend_q <= 1'b0;
        else if (tick)                 pend_q <= 1'b1;
    end

    // Count burst beats.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_BURST) beat_q <= '0;
        else                            beat_q <= beat_q + 1'b1;
    end

    // Move to the next line after a burst, wrapping at the end of the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            sweep_q <= 1'b0;
        end else begin
            sweep_q <= 1'b0;
            if (last_beat) begin
                if (line_q == LINE_W'(LINES - 1)) begin
                    line_q  <= '0;
                    sweep_q <= 1'b1;
                end else begin
                    line_q <= line_q + 1'b1;
                end
            end
        end
    end

    assign clr        = (st_q == ST_REQ);
    assign cap_en     = (st_q == ST_LOAD);
    assign shift2     = (st_q == ST_BURST);
    assign scan_req   = (st_q == ST_REQ);
    assign wr_en      = (st_q == ST_BURST);
    assign wr_line    = line_q;
    assign wr_pair    = wr_en ? (PAIR_W'(PAIR_BASE) + PAIR_W'(beat_q)) : '0;
    assign sweep_done = sweep_q;
endmodule

// File: rtl/line_capture_burst.sv
// Module line_capture_burst: requests a spectral scan each interval, folds its
// points into delay cells and writes them as one burst into the target raster
// line, below the reserved top dots.
// Assumes: CELLS and RSV_DOTS are even; ln_cur is valid with ln_start.
module line_capture_burst #(
    parameter int CELLS     = 100,
    parameter int RSV_DOTS  = 28,
    parameter int LINES     = 280,
    parameter int SEC_TICKS = 1_200_000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  smp_stb,
    input  logic                                  smp_bit,
    input  logic                                  ln_start,
    input  logic [$clog2(LINES)-1:0]              ln_cur,
    output logic                                  scan_req,
    output logic                                  wr_en,
    output logic [$clog2(LINES)-1:0]              wr_line,
    output logic [$clog2((RSV_DOTS+CELLS)/2)-1:0] wr_pair,
    output logic                                  wr_even,
    output logic                                  wr_odd,
    output logic                                  sweep_done
);
    logic       tick;
    logic       clr;
    logic       cap_en;
    logic       shift2;
    logic       load_done;
    logic [1:0] cell_lo;

    lcap_sec_timer #(.TICKS(SEC_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    lcap_pair_buffer #(.CELLS(CELLS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cap_en    (cap_en),
        .smp_stb   (smp_stb),
        .smp_bit   (smp_bit),
        .shift2    (shift2),
        .load_done (load_done),
        .cell_lo   (cell_lo)
    );

    lcap_sequencer #(
        .CELLS    (CELLS),
        .RSV_DOTS (RSV_DOTS),
        .LINES    (LINES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_done  (load_done),
        .ln_start   (ln_start),
        .ln_cur     (ln_cur),
        .clr        (clr),
        .cap_en     (cap_en),
        .shift2     (shift2),
        .scan_req   (scan_req),
        .wr_en      (wr_en),
        .wr_line    (wr_line),
        .wr_pair    (wr_pair),
        .sweep_done (sweep_done)
    );

    // Data leaves the register only during a burst.
    assign wr_even = wr_en & cell_lo[0];
    assign wr_odd  = wr_en & cell_lo[1];
endmodule

// File: rtl/lcap_checker.sv
// Module lcap_checker: temporal properties of line_capture_burst at its ports.
// Assumes: bound to every instance of line_capture_burst.
module lcap_checker #(
    parameter int CELLS    = 100,
    parameter int RSV_DOTS = 28,
    parameter int LINES    = 280
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  ln_start,
    input logic [$clog2(LINES)-1:0]              ln_cur,
    input logic                                  scan_req,
    input logic                                  wr_en,
    input logic [$clog2(LINES)-1:0]              wr_line,
    input logic [$clog2((RSV_DOTS+CELLS)/2)-1:0] wr_pair,
    input logic                                  sweep_done
);
    localparam int PAIR_W    = $clog2((RSV_DOTS + CELLS) / 2);
    localparam int PAIR_BASE = RSV_DOTS / 2;
    localparam int LINE_W    = $clog2(LINES);

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> !scan_req); // R1

    AST_BURST_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> ($past(ln_start) && $past(ln_cur) == wr_line)); // R4

    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_pair == PAIR_W'($past(wr_pair) + 1'b1))); // R4

    AST_PAIR_ABOVE_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_pair) >= PAIR_BASE)); // R5

    AST_LINE_MOVES_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_line != $past(wr_line)) |-> ($past(wr_en) && !wr_en)); // R6

    AST_WRAP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (wr_line == '0 && $past(wr_line) == LINE_W'(LINES - 1))); // R7

    AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scan_req); // R8
endmodule

bind line_capture_burst lcap_checker #(
    .CELLS    (CELLS),
    .RSV_DOTS (RSV_DOTS),
    .LINES    (LINES)
) u_lcap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ln_start   (ln_start),
    .ln_cur     (ln_cur),
    .scan_req   (scan_req),
    .wr_en      (wr_en),
    .wr_line    (wr_line),
    .wr_pair    (wr_pair),
    .sweep_done (sweep_done)
);

// File: tb/test_line_capture_burst.sv
// Bench for line_capture_burst: a behavioural reference model, compared every cycle.
module test_line_capture_burst;
    localparam int CELLS  = 100;
    localparam int RSV    = 28;
    localparam int LINES  = 4;
    localparam int SEC    = 600;
    localparam int LW     = $clog2(LINES);
    localparam int PW     = $clog2((RSV + CELLS) / 2);
    localparam int PTS    = 2 * CELLS;
    localparam int BEATS  = CELLS / 2;
    localparam int BASE   = RSV / 2;
    localparam int LPER   = 64;
    localparam int RUN    = 14000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_stb, smp_bit, ln_start;
    logic [LW-1:0] ln_cur;
    logic          scan_req, wr_en, wr_even, wr_odd, sweep_done;
    logic [LW-1:0] wr_line;
    logic [PW-1:0] wr_pair;

    always #10 clk = ~clk;

    line_capture_burst #(
        .CELLS(CELLS), .RSV_DOTS(RSV), .LINES(LINES), .SEC_TICKS(SEC)
    ) i_line_capture_burst (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_bit(smp_bit),
        .ln_start(ln_start), .ln_cur(ln_cur), .scan_req(scan_req),
        .wr_en(wr_en), .wr_line(wr_line), .wr_pair(wr_pair),
        .wr_even(wr_even), .wr_odd(wr_odd), .sweep_done(sweep_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit pat(int s, int i);
        if (i >= PTS) return 1'b1;
        case (s % 5)
            0: return 1'b0;
            1: return 1'b1;
            2: return (i % 2 == 1) && ((i / 2) % 3 == 0);
            3: return (i % 2 == 0) && ((i / 2) % 7 == 1);
            default: return ((i * 37 + s * 11) % 5) < 2;
        endcase
    endfunction

    // Reference model: 0 idle, 1 request, 2 load, 3 wait, 4 burst.
    int m_sec, m_st, m_pend, m_pts, m_beat, m_line, m_sdone;
    bit m_acc;
    bit cq[$];
    int delayed_cnt = 0, sweep_cnt = 0, scan_cnt = 0, stray_cnt = 0;

    always @(posedge clk) begin : model
        int st0;
        bit tk;
        if (!rst_n) begin
            m_sec = 0; m_st = 0; m_pend = 0; m_pts = 0; m_beat = 0;
            m_line = 0; m_sdone = 0; m_acc = 0; cq.delete();
        end else begin
            st0 = m_st;
            tk  = (m_sec == SEC - 1);
            m_sdone = 0;
            if (st0 != 0 && tk) begin
                m_pend = 1;
                if (st0 >= 3) delayed_cnt++;
            end
            if (smp_stb && st0 != 2) stray_cnt++;
            case (st0)
                0: if (tk || m_pend != 0) begin m_st = 1; m_pend = 0; scan_cnt++; end
                1: begin m_st = 2; m_pts = 0; cq.delete(); end
                2: if (smp_stb) begin
                       if (m_pts % 2 == 0) m_acc = smp_bit;
                       else cq.push_back(m_acc | smp_bit);
                       m_pts++;
                       if (m_pts == PTS) m_st = 3;
                   end
                3: if (ln_start && int'(ln_cur) == m_line) begin m_st = 4; m_beat = 0; end
                default: begin
                    void'(cq.pop_front());
                    void'(cq.pop_front());
                    m_beat++;
                    if (m_beat == BEATS) begin
                        m_st = 0;
                        if (m_line == LINES - 1) begin m_line = 0; m_sdone = 1; sweep_cnt++; end
                        else m_line++;
                    end
                end
            endcase
            m_sec = tk ? 0 : m_sec + 1;
        end
    end

    // Compare every output with the model away from the clock edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            chk("R1", "scan_req", int'(scan_req), int'(m_st == 1));
            chk("R4", "wr_en", int'(wr_en), int'(m_st == 4));
            chk("R6", "wr_line", int'(wr_line), m_line);
            chk("R7", "sweep_done", int'(sweep_done), m_sdone);
            chk("R5", "wr_pair", int'(wr_pair), (m_st == 4) ? BASE + m_beat : 0);
            chk("R3", "wr_even", int'(wr_even), (m_st == 4 && cq.size() > 0) ? int'(cq[0]) : 0);
            chk("R3", "wr_odd", int'(wr_odd), (m_st == 4 && cq.size() > 1) ? int'(cq[1]) : 0);
        end
    end

    // Spectrum source: one point every second cycle after a request, plus stray strobes.
    initial begin : source
        int left = 0, idx = 0, scan_no = 0;
        bit ph = 0;
        smp_stb = 0; smp_bit = 0;
        forever begin
            @(negedge clk);
            #2;
            if (left > 0) begin
                if (ph) begin
                    smp_stb = 1; smp_bit = pat(scan_no, idx); idx++; left--;
                end else smp_stb = 0;
                ph = ~ph;
            end else begin
                smp_stb = (rst_n === 1'b1) && ($urandom_range(0, 9) == 0); // R2 strays
                smp_bit = 1'b1;
            end
            if (scan_req === 1'b1 && left == 0) begin
                left = PTS + 4; idx = 0; ph = 0; scan_no++;
            end
        end
    end

    // Raster: one line-start pulse every LPER cycles, lines in order.
    initial begin : raster
        int cnt = 0;
        ln_start = 0; ln_cur = '0;
        forever begin
            @(negedge clk);
            #2;
            if (cnt == LPER - 1) begin
                cnt = 0; ln_start = 1; ln_cur = LW'(ln_cur + 1'b1);
            end else begin
                cnt++; ln_start = 0;
            end
        end
    end

    initial begin : main
        rst_n = 0;
        repeat (4) @(negedge clk);
        chk("R9", "reset scan_req", int'(scan_req), 0);
        chk("R9", "reset wr_en", int'(wr_en), 0);
        chk("R9", "reset sweep_done", int'(sweep_done), 0);
        chk("R9", "reset wr_line", int'(wr_line), 0);
        #2 rst_n = 1;
        repeat (RUN) @(negedge clk);
        chk("R1", "scans issued >= 12", int'(scan_cnt >= 12), 1);
        chk("R2", "stray strobes seen", int'(stray_cnt > 0), 1);
        chk("R7", "sweeps completed >= 2", int'(sweep_cnt >= 2), 1);
        chk("R8", "intervals expired while busy", int'(delayed_cnt > 0), 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule